// File: doc/BRIEF.md
# I2C SCL Split High/Low Divider

This block turns a fast synchronous clock into the SCL waveform of an I2C master. The low and high halves of each SCL period are timed separately. Each half is counted as a number of prescale ticks, with one tick every eight input clocks, so a phase lasts eight times its field value plus one. Both 16-bit fields sit in one 32-bit configuration word, which software writes directly. The block does not derive divisors from bus timing specifications.

Besides the SCL level, the block produces three single-cycle strobes for the bit engine that drives SDA. One marks the first cycle of a low phase, one marks the first cycle of a high phase, and one marks the middle of the low phase, where SDA may safely change. A slave may stretch the clock: while SCL is released but the sensed line is still low, the high-phase count stops. A new configuration word is captured only when a low phase begins, so a change during a period never cuts a phase short. Clearing the enable releases SCL and clears all counting state. The next enable starts a fresh low phase.

Top module: `i2c_scl_phase_gen`

## Requirements
- R1: While `rst` is high, `scl_o` is 1 and `low_start`, `high_start` and `low_mid` are 0, whatever `en` is.
- R2: A low phase (`scl_o` = 0) lasts 8 × (L + 1) clock cycles, where L is `div_cfg[15:0]`.
- R3: A high phase (`scl_o` = 1 between two low phases) lasts 8 × (H + 1) clock cycles when not stretched, where H is `div_cfg[31:16]`.
- R4: A field value of 0 gives a phase of exactly 8 clock cycles.
- R5: `low_start` is high for exactly one cycle, the first cycle in which `scl_o` is 0. `high_start` is high for exactly one cycle, the first cycle in which `scl_o` is 1 again. Each occurs once per SCL period.
- R6: `low_mid` is high for exactly one cycle per low phase, at 4 × (L + 1) cycles after the `low_start` cycle (the `low_start` cycle counts as offset 0).
- R7: Both fields are captured from `div_cfg` in the cycle a low phase begins. A change of `div_cfg` inside a period does not alter that period's low or high length, and takes effect from the next low phase.
- R8: One cycle after `en` is sampled low, `scl_o` is 1 and all strobes are 0. One cycle after `en` is sampled high from that idle state, a full-length low phase begins with `low_start`.
- R9: Every clock cycle of a high phase in which `scl_in` is 0 lengthens that high phase by one cycle, and `scl_o` stays 1 meanwhile.
- R10: `scl_in` has no effect on the length of a low phase.
- R11: One unstretched SCL period lasts 8 × (L + H + 2) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, the source of all timing |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases SCL and clears counters |
| div_cfg | input | 32 | High-phase field in bits 31:16, low-phase field in bits 15:0 |
| scl_in | input | 1 | Sensed SCL line level, synchronous to `clk` |
| scl_o | output | 1 | SCL drive level: 0 pulls low, 1 releases |
| low_start | output | 1 | One-cycle strobe in the first cycle of a low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of a high phase |
| low_mid | output | 1 | One-cycle strobe at the middle of the low phase |

## Verification
The divider is driven with field pairs that separate the two halves. Both fields at zero show the minimum phase. A nonzero low with a zero high, and the reverse, catch swapped fields. Unequal small values catch a shared count. A field of 0x100 in either half proves that upper field bits land in the right place. A configuration change inside a low phase shows that the new value waits for the next period. A held-low line during the high phase, and a forced-high line during the low phase, show that stretching affects only the high count. Dropping the enable in mid-phase and restarting shows the release and the full-length restart.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  // Phase of the SCL waveform generator.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Default width of one phase field and default tick prescale.
  localparam int SCL_FIELD_W  = 16;
  localparam int SCL_PRESCALE = 8;

endpackage

// File: rtl/scl_prescale.sv
// Tick generator: one tick every PRESCALE advancing cycles.
module scl_prescale #(
  parameter int PRESCALE = 8,
  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [PRE_W-1:0] pre_o,
  output logic             tick_o
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  assign tick_o = adv && (pre_o == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_o <= '0;
    end else if (adv) begin
      pre_o <= tick_o ? '0 : pre_o + 1'b1;
    end
  end

endmodule

// File: rtl/scl_phase_cnt.sv
// Counts prescale ticks within one phase up to a programmable limit.
module scl_phase_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_o,
  output logic         at_limit_o
);

  assign at_limit_o = (cnt_o == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
    end else if (inc && !at_limit_o) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/scl_div_shadow.sv
// Holds the active high/low field pair; reloads only on request.
module scl_div_shadow #(
  parameter int W = 16,
  localparam int CFG_W = 2 * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [W-1:0]     lo_o,
  output logic [W-1:0]     hi_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (load) begin
      lo_o <= cfg_in[W-1:0];
      hi_o <= cfg_in[CFG_W-1:W];
    end
  end

endmodule

// File: rtl/i2c_scl_phase_gen.sv
module i2c_scl_phase_gen
  import i2c_scl_pkg::*;
#(
  parameter int FIELD_W  = SCL_FIELD_W,
  parameter int PRESCALE = SCL_PRESCALE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [2*FIELD_W-1:0] div_cfg,
  input  logic                 scl_in,
  output logic                 scl_o,
  output logic                 low_start,
  output logic                 high_start,
  output logic                 low_mid
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int EL_W  = FIELD_W + PRE_W + 1;

  generate
    if (PRESCALE < 2 || (PRESCALE % 2) != 0) begin : g_bad_prescale
      $error("PRESCALE must be even and at least 2");
    end
  endgenerate

  scl_phase_e         ph_q, ph_n;
  logic [FIELD_W-1:0] lo_q, hi_q, limit, cnt;
  logic [PRE_W-1:0]   pre;
  logic               tick, at_limit, done, adv;
  logic               enter_low, enter_high, clr_cnt, mid_hit;
  logic [EL_W-1:0]    elapsed, mid_at;

  // Phase control
  always_comb begin
    adv        = (ph_q == PH_LOW) || ((ph_q == PH_HIGH) && scl_in);
    limit      = (ph_q == PH_HIGH) ? hi_q : lo_q;
    done       = tick && at_limit;
    enter_low  = en && ((ph_q == PH_IDLE) || ((ph_q == PH_HIGH) && done));
    enter_high = en && (ph_q == PH_LOW) && done;
    clr_cnt    = !en || enter_low || enter_high || (ph_q == PH_IDLE);
    if (!en)            ph_n = PH_IDLE;
    else if (enter_low)  ph_n = PH_LOW;
    else if (enter_high) ph_n = PH_HIGH;
    else                 ph_n = ph_q;
  end

  // Mid-low position: cycles elapsed in phase vs half the low length
  always_comb begin
    elapsed = EL_W'(cnt) * EL_W'(PRESCALE) + EL_W'(pre);
    mid_at  = ((EL_W'(lo_q) + EL_W'(1)) * EL_W'(PRESCALE)) / EL_W'(2)
              - EL_W'(1);
    mid_hit = en && (ph_q == PH_LOW) && !done && (elapsed == mid_at);
  end

  scl_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_cnt),
    .adv    (adv),
    .pre_o  (pre),
    .tick_o (tick)
  );

  scl_phase_cnt #(.W(FIELD_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_cnt),
    .inc        (tick),
    .limit      (limit),
    .cnt_o      (cnt),
    .at_limit_o (at_limit)
  );

  scl_div_shadow #(.W(FIELD_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load   (enter_low),
    .cfg_in (div_cfg),
    .lo_o   (lo_q),
    .hi_o   (hi_q)
  );

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      scl_o      <= 1'b1;
      low_start  <= 1'b0;
      high_start <= 1'b0;
      low_mid    <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      scl_o      <= (ph_n != PH_LOW);
      low_start  <= enter_low;
      high_start <= enter_high;
      low_mid    <= mid_hit;
    end
  end

endmodule

// File: rtl/i2c_scl_phase_gen_chk.sv
module i2c_scl_phase_gen_chk
  import i2c_scl_pkg::*;
#(
  parameter int FIELD_W = SCL_FIELD_W
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               scl_in,
  input logic               scl_o,
  input logic               low_start,
  input logic               high_start,
  input logic               low_mid,
  input scl_phase_e         ph_q,
  input logic [FIELD_W-1:0] lo_q,
  input logic [FIELD_W-1:0] hi_q
);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !low_start && !high_start && !low_mid));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_start, high_start, low_mid}));

  p_low_entry_r5: assert property (@(posedge clk) disable iff (rst)
    low_start |-> !scl_o);

  p_fall_marked_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> low_start);

  p_high_entry_r5: assert property (@(posedge clk) disable iff (rst)
    high_start |-> (scl_o && !$past(scl_o)));

  p_mid_in_low_r6: assert property (@(posedge clk) disable iff (rst)
    low_mid |-> !scl_o);

  p_min_low_r4: assert property (@(posedge clk) disable iff (rst)
    (en && $fell(scl_o)) |=> !scl_o);

  p_stretch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (en && ph_q == PH_HIGH && !scl_in) |=> scl_o);

  p_shadow_lo_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(lo_q) |-> low_start);

  p_shadow_hi_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(hi_q) |-> low_start);

endmodule

bind i2c_scl_phase_gen i2c_scl_phase_gen_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .scl_in     (scl_in),
  .scl_o      (scl_o),
  .low_start  (low_start),
  .high_start (high_start),
  .low_mid    (low_mid),
  .ph_q       (ph_q),
  .lo_q       (lo_q),
  .hi_q       (hi_q)
);

// File: tb/i2c_scl_phase_gen_tb.sv
module i2c_scl_phase_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] div_cfg = '0;
  logic        hold_low = 1'b0;
  logic        force_hi = 1'b0;
  logic        scl_in;
  logic        scl_o, low_start, high_start, low_mid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Line model: open drain plus a stretching slave and a forced-high override
  assign scl_in = force_hi | (scl_o & ~hold_low);

  always #2 clk = ~clk;

  i2c_scl_phase_gen u_dut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .div_cfg    (div_cfg),
    .scl_in     (scl_in),
    .scl_o      (scl_o),
    .low_start  (low_start),
    .high_start (high_start),
    .low_mid    (low_mid)
  );

  // {div_cfg[31:0], expected low cycles[15:0], expected high cycles[15:0]}
  localparam logic [63:0] VEC [7] = '{
    64'h0000_0000_0008_0008,
    64'h0000_0001_0010_0008,
    64'h0003_0000_0008_0020,
    64'h0002_0004_0028_0018,
    64'h0009_0009_0050_0050,
    64'h0001_0100_0808_0010,
    64'h0100_0002_0018_0808
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Measures one full SCL period starting at the next low_start sample.
  task automatic run_cycle(input int stretch, input bit fh, input bit chg,
                           input logic [31:0] nd,
                           output int lc, output int hc, output int midoff,
                           output int nmid, output int nls, output int nhs);
    lc = 0; hc = 0; midoff = -1; nmid = 0; nls = 0; nhs = 0;
    while (!low_start) @(negedge clk);
    force_hi = fh;
    while (!scl_o) begin
      if (low_mid) begin nmid++; midoff = lc; end
      if (low_start) nls++;
      if (high_start) nhs++;
      lc++;
      if (chg && lc == 2) div_cfg = nd;
      @(negedge clk);
    end
    force_hi = 1'b0;
    if (stretch > 0) hold_low = 1'b1;
    while (scl_o) begin
      if (high_start) nhs++;
      if (low_start) nls++;
      if (low_mid) nmid++;
      if (hc == stretch) hold_low = 1'b0;
      hc++;
      @(negedge clk);
    end
    hold_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int lc, hc, mo, nm, nl, nh, lo, hi;

    // R1: reset dominates enable
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl released in reset", scl_o, 1);
    chk({low_start, high_start, low_mid} == 3'b000, "R1 strobes quiet in reset",
        {low_start, high_start, low_mid}, 0);
    en = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < 7; i++) begin
      en = 1'b0;
      repeat (2) @(negedge clk);
      div_cfg = VEC[i][63:32];
      lo = int'(div_cfg[15:0]);
      hi = int'(div_cfg[31:16]);
      en = 1'b1;
      run_cycle(0, 1'b0, 1'b0, 32'h0, lc, hc, mo, nm, nl, nh);
      chk(lc == int'(VEC[i][31:16]), (lo == 0) ? "R4 zero low field" : "R2 low length",
          lc, int'(VEC[i][31:16]));
      chk(hc == int'(VEC[i][15:0]), (hi == 0) ? "R4 zero high field" : "R3 high length",
          hc, int'(VEC[i][15:0]));
      chk(mo == 4 * (lo + 1), "R6 mid offset", mo, 4 * (lo + 1));
      chk(nm == 1, "R6 one mid strobe", nm, 1);
      chk(nl == 1 && nh == 1, "R5 one start strobe each", nl * 10 + nh, 11);
      chk(lc + hc == 8 * (lo + hi + 2), "R11 period", lc + hc, 8 * (lo + hi + 2));
    end

    // R7: change inside a low phase takes effect next period
    en = 1'b0;
    repeat (2) @(negedge clk);
    div_cfg = 32'h0003_0002;
    en = 1'b1;
    run_cycle(0, 1'b0, 1'b1, 32'h0001_0005, lc, hc, mo, nm, nl, nh);
    chk(lc == 24, "R7 current low kept", lc, 24);
    chk(hc == 32, "R7 current high kept", hc, 32);
    run_cycle(0, 1'b0, 1'b0, 32'h0, lc, hc, mo, nm, nl, nh);
    chk(lc == 48, "R7 new low applied", lc, 48);
    chk(hc == 16, "R7 new high applied", hc, 16);

    // R9: stretching slave holds the line for 7 cycles of the high phase
    en = 1'b0;
    repeat (2) @(negedge clk);
    div_cfg = 32'h0002_0001;
    en = 1'b1;
    run_cycle(7, 1'b0, 1'b0, 32'h0, lc, hc, mo, nm, nl, nh);
    chk(lc == 16, "R9 low unaffected", lc, 16);
    chk(hc == 31, "R9 stretched high", hc, 31);
    chk(nh == 1, "R9 single high start", nh, 1);

    // R10: line forced high during the low phase changes nothing
    en = 1'b0;
    repeat (2) @(negedge clk);
    div_cfg = 32'h0000_0003;
    en = 1'b1;
    run_cycle(0, 1'b1, 1'b0, 32'h0, lc, hc, mo, nm, nl, nh);
    chk(lc == 32, "R10 low length with line high", lc, 32);
    chk(hc == 8, "R10 high length after", hc, 8);

    // R8: disable mid-phase, then restart
    en = 1'b0;
    repeat (2) @(negedge clk);
    div_cfg = 32'h0001_0001;
    en = 1'b1;
    while (!low_start) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R8 released after disable", scl_o, 1);
    chk({low_start, high_start, low_mid} == 3'b000, "R8 strobes quiet after disable",
        {low_start, high_start, low_mid}, 0);
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !low_start, "R8 stays idle", scl_o, 1);
    en = 1'b1;
    @(negedge clk);
    chk(low_start == 1'b1 && scl_o == 1'b0, "R8 restart with low_start",
        {low_start, scl_o}, 2);
    run_cycle(0, 1'b0, 1'b0, 32'h0, lc, hc, mo, nm, nl, nh);
    chk(lc == 16, "R8 full low after restart", lc, 16);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule